// File: doc/BRIEF.md
# Low-Order Interleaved Banked RAM

This block is a word-addressed single-port RAM assembled from small leaf banks of eight words each (by default), composed over several levels so that every level fans out to eight sub-memories. The distinguishing choice is where the bank number comes from. The least-significant address bits pick the bank, and the most-significant bits pick the word inside it. Consecutive addresses therefore fall into different banks.

The address is used twice. A decoder steers the load strobe to one bank, and a tree of eight-way multiplexers, one stage per composition level, brings that bank's word to the output. Reads are combinational from stored state. A write is committed on the rising clock edge. Any caller sees an ordinary RAM: an address returns the last value written to it, whatever the internal placement.

Top module: `ilv_banked_ram`

## Requirements
- R1: Data words are `DATA_W` bits wide (16 by default). The address is `BANK_AW*LEVELS` bits wide, which gives 9 bits and 512 words by default. The lowest address (0), the highest address (511) and words with every bit set are stored exactly.
- R2: `rd_data` is a combinational function of `addr` and the stored words. Changing `addr` between clock edges changes `rd_data` with no edge in between.
- R3: When `load` is 1 at a rising edge, the word at `addr` takes `wr_data`. From the next cycle onward, `rd_data` at that address shows the new value.
- R4: When `load` is 0 at a rising edge, no stored word changes, whatever `wr_data` and `addr` carry. With `load` at 0, no bank write enable is active.
- R5: A write changes only the addressed word. Neighbouring addresses, including addresses in the same bank, keep their contents.
- R6: The bank index is the low `BANK_AW*(LEVELS-1)` address bits (`addr[5:0]` by default). The word within the bank is the remaining high bits (`addr[8:6]`). When `load` is 1, exactly the bank enable numbered `addr[5:0]` is active. Eight consecutive addresses each hold their own distinct value.
- R7: Across the whole address range and under any mix of reads and writes, a read returns the last value written to that address.
- R8: During a cycle with `load` at 1, `rd_data` shows the value stored before the edge. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| wr_data | input | DATA_W | Word to store when load is high |
| addr | input | BANK_AW*LEVELS | Word address for both read and write |
| load | input | 1 | Write strobe for the addressed word |
| rd_data | output | DATA_W | Combinational read of the addressed word |

## Verification
There are two kinds of result, and each is due at a different point. A read result is due in the same cycle as its address. A write result is due in the cycle after the edge that commits it. The bench drives every input on the falling edge and samples `rd_data` one nanosecond later, before the next rising edge, so the sample sees only the stored state and the current address. The bench's reference array is updated only after the rising edge of a cycle whose strobe it drove high. This keeps the expected value to the old word during a write cycle and to the new word from the following cycle.

// File: rtl/ilv_ram_pkg.sv
package ilv_ram_pkg;

   // Default geometry: eight words per leaf, three composition levels.
   localparam int ILV_DEF_DATA_W  = 16;
   localparam int ILV_DEF_BANK_AW = 3;
   localparam int ILV_DEF_LEVELS  = 3;

   // Number of words entering mux stage `stage` when n_leaf leaves
   // are reduced by a factor 2**sel_aw at every stage.
   function automatic int stage_words(input int n_leaf, input int sel_aw, input int stage);
      return n_leaf >> (sel_aw * stage);
   endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter  int DATA_W  = 16,
   parameter  int WORD_AW = 3,
   localparam int WORDS   = 1 << WORD_AW
) (
   input  logic               clk,
   input  logic               we,
   input  logic [WORD_AW-1:0] word_sel,
   input  logic [DATA_W-1:0]  wr_word,
   output logic [DATA_W-1:0]  rd_word
);

   logic [DATA_W-1:0] cells [WORDS];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[word_sel] <= wr_word;
      end
   end

   // Read straight from stored state; no output register.
   assign rd_word = cells[word_sel];

endmodule

// File: rtl/ilv_load_decode.sv
module ilv_load_decode #(
   parameter  int SEL_W   = 6,
   localparam int N_BANKS = 1 << SEL_W
) (
   input  logic               load,
   input  logic [SEL_W-1:0]   sel,
   output logic [N_BANKS-1:0] bank_we
);

   for (genvar b = 0; b < N_BANKS; b++) begin : g_en
      assign bank_we[b] = load && (sel == SEL_W'(b));
   end

endmodule

// File: rtl/ilv_read_mux.sv
module ilv_read_mux
   import ilv_ram_pkg::*;
#(
   parameter  int DATA_W = 16,
   parameter  int SEL_AW = 3,
   parameter  int STAGES = 2,
   localparam int FAN    = 1 << SEL_AW,
   localparam int N_IN   = 1 << (SEL_AW * STAGES)
) (
   input  logic [N_IN*DATA_W-1:0]   words_in,
   input  logic [SEL_AW*STAGES-1:0] sel,
   output logic [DATA_W-1:0]        word_out
);

   // Stage s consumes sel bits [s*SEL_AW +: SEL_AW], lowest bits first,
   // so the leaf chosen is exactly the binary value of sel.
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int N_SIN  = stage_words(N_IN, SEL_AW, s);
      localparam int N_SOUT = stage_words(N_IN, SEL_AW, s + 1);

      logic [N_SIN*DATA_W-1:0]  lvl_in;
      logic [N_SOUT*DATA_W-1:0] lvl_out;
      logic [SEL_AW-1:0]        pick;

      assign pick = sel[s*SEL_AW +: SEL_AW];

      if (s == 0) begin : g_first
         assign lvl_in = words_in;
      end else begin : g_next
         assign lvl_in = g_stage[s-1].lvl_out;
      end

      for (genvar g = 0; g < N_SOUT; g++) begin : g_node
         logic [FAN*DATA_W-1:0] group;
         assign group = lvl_in[g*FAN*DATA_W +: FAN*DATA_W];
         assign lvl_out[g*DATA_W +: DATA_W] = group[pick*DATA_W +: DATA_W];
      end
   end

   assign word_out = g_stage[STAGES-1].lvl_out;

endmodule

// File: rtl/ilv_banked_ram.sv
module ilv_banked_ram
   import ilv_ram_pkg::*;
#(
   parameter  int DATA_W    = ILV_DEF_DATA_W,
   parameter  int BANK_AW   = ILV_DEF_BANK_AW,
   parameter  int LEVELS    = ILV_DEF_LEVELS,
   localparam int ADDR_W    = BANK_AW * LEVELS,
   localparam int SEL_W     = BANK_AW * (LEVELS - 1),
   localparam int NUM_BANKS = 1 << SEL_W
) (
   input  logic              clk,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic              load,
   output logic [DATA_W-1:0] rd_data
);

   // Elaboration-time parameter checks.
   if (DATA_W < 1) begin : g_bad_data_w
      $error("ilv_banked_ram: DATA_W must be at least 1");
   end
   if (BANK_AW < 1) begin : g_bad_bank_aw
      $error("ilv_banked_ram: BANK_AW must be at least 1");
   end
   if (LEVELS < 1) begin : g_bad_levels
      $error("ilv_banked_ram: LEVELS must be at least 1");
   end
   if (ADDR_W > 20) begin : g_bad_depth
      $error("ilv_banked_ram: depth above 2**20 words is not supported");
   end

   logic [NUM_BANKS-1:0]        bank_we;
   logic [NUM_BANKS*DATA_W-1:0] leaf_words;
   logic [BANK_AW-1:0]          word_idx;

   // High-order bits address inside a leaf; low-order bits pick the leaf.
   assign word_idx = addr[ADDR_W-1 -: BANK_AW];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_leaf
      ilv_bank #(
         .DATA_W  (DATA_W),
         .WORD_AW (BANK_AW)
      ) bank_i (
         .clk      (clk),
         .we       (bank_we[b]),
         .word_sel (word_idx),
         .wr_word  (wr_data),
         .rd_word  (leaf_words[b*DATA_W +: DATA_W])
      );
   end

   if (SEL_W == 0) begin : g_single
      // One leaf only: no decode, no multiplexing.
      assign bank_we = load;
      assign rd_data = leaf_words;
   end else begin : g_interleaved
      logic [SEL_W-1:0] bank_sel;
      assign bank_sel = addr[SEL_W-1:0];

      ilv_load_decode #(
         .SEL_W (SEL_W)
      ) dec_i (
         .load    (load),
         .sel     (bank_sel),
         .bank_we (bank_we)
      );

      ilv_read_mux #(
         .DATA_W (DATA_W),
         .SEL_AW (BANK_AW),
         .STAGES (LEVELS - 1)
      ) mux_i (
         .words_in (leaf_words),
         .sel      (bank_sel),
         .word_out (rd_data)
      );
   end

endmodule

// File: rtl/ilv_banked_ram_chk.sv
module ilv_banked_ram_chk #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 9,
   parameter int NUM_BANKS = 64
) (
   input logic                 clk,
   input logic [DATA_W-1:0]    wr_data,
   input logic [ADDR_W-1:0]    addr,
   input logic                 load,
   input logic [DATA_W-1:0]    rd_data,
   input logic [NUM_BANKS-1:0] bank_we
);

   // Becomes 1 after the first edge, so $past never reaches before time zero.
   logic past_ok = 1'b0;
   always_ff @(posedge clk) past_ok <= 1'b1;

   // Expected enable pattern from the interleaving rule: bank = addr mod banks.
   logic [NUM_BANKS-1:0] exp_we;
   always_comb begin
      exp_we = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (load && ((int'(addr) % NUM_BANKS) == b)) exp_we[b] = 1'b1;
      end
   end

   AST_WE_AT_MOST_ONE: assert property (@(posedge clk) $onehot0(bank_we)); // R6
   AST_WE_ONE_ON_LOAD: assert property (@(posedge clk) load |-> $countones(bank_we) == 1); // R6
   AST_WE_LOW_BITS: assert property (@(posedge clk) bank_we == exp_we); // R6
   AST_NO_WE_IDLE: assert property (@(posedge clk) !load |-> bank_we == '0); // R4
   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!past_ok)
      ($past(load) && addr == $past(addr)) |-> rd_data == $past(wr_data)); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!past_ok)
      (!$past(load) && $stable(addr)) |-> $stable(rd_data)); // R4

endmodule

bind ilv_banked_ram ilv_banked_ram_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_BANKS (NUM_BANKS)
) chk_i (
   .clk     (clk),
   .wr_data (wr_data),
   .addr    (addr),
   .load    (load),
   .rd_data (rd_data),
   .bank_we (bank_we)
);

// File: tb/ilv_banked_ram_tb_top.sv
`timescale 1ns/1ps
module ilv_banked_ram_tb_top;

   localparam int DW    = 16;
   localparam int AW    = 9;
   localparam int DEPTH = 1 << AW;
   localparam int NB    = 64;

   logic          clk = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] addr = '0;
   logic          load = 1'b0;
   logic [DW-1:0] rd_data;

   logic [DW-1:0] model [DEPTH];
   int n_checks = 0;
   int n_err    = 0;

   always #2 clk = ~clk;   // 250 MHz

   ilv_banked_ram dut_i (
      .clk     (clk),
      .wr_data (wr_data),
      .addr    (addr),
      .load    (load),
      .rd_data (rd_data)
   );

   function automatic logic [DW-1:0] fill_val(input int a);
      return DW'(a * 16'h9E37) ^ 16'h5A5A;
   endfunction

   task automatic check(input string req, input int a, input logic [DW-1:0] got,
                        input logic [DW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s addr=%0d got=%h expected=%h", req, a, got, exp);
      end
   endtask

   // Drive inputs on the falling edge; outputs settle 1 ns later.
   task automatic drive(input int a, input logic [DW-1:0] d, input logic ld);
      @(negedge clk);
      addr    = AW'(a);
      wr_data = d;
      load    = ld;
      #1;
   endtask

   task automatic commit();
      @(posedge clk);
      if (load) model[addr] = wr_data;
   endtask

   task automatic write_word(input int a, input logic [DW-1:0] d);
      drive(a, d, 1'b1);
      commit();
   endtask

   task automatic read_check(input int a, input string req);
      drive(a, DW'($urandom), 1'b0);
      check(req, a, rd_data, model[a]);
      commit();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: run did not complete got=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (2) @(posedge clk);

      // R7: fill every address, then sweep read.
      for (int a = 0; a < DEPTH; a++) write_word(a, fill_val(a));
      for (int a = 0; a < DEPTH; a++) read_check(a, "R7 sweep");

      // R1: boundary addresses and full-width words.
      write_word(0, 16'hFFFF);
      write_word(DEPTH - 1, 16'h8001);
      read_check(0, "R1 lowest address");
      read_check(DEPTH - 1, "R1 highest address");
      write_word(DEPTH - 1, 16'hFFFF);
      read_check(DEPTH - 1, "R1 all ones");

      // R6: consecutive addresses land in distinct banks, keep distinct values.
      for (int a = 40; a < 48; a++) write_word(a, 16'hC000 | DW'(a));
      for (int a = 40; a < 48; a++) read_check(a, "R6 consecutive");
      // R6: two words of one bank (same low bits, different high bits).
      write_word(5, 16'h1111);
      write_word(5 + NB, 16'h2222);
      read_check(5, "R6 same bank word0");
      read_check(5 + NB, "R6 same bank word1");

      // R4: load low with junk data must not alter anything.
      for (int i = 0; i < 16; i++) begin
         int a;
         a = int'($urandom % DEPTH);
         drive(a, ~model[a], 1'b0);
         commit();
         read_check(a, "R4 load low");
      end

      // R5 and R3: single write leaves neighbours alone, shows next cycle.
      for (int i = 0; i < 64; i++) begin
         int a;
         a = int'($urandom % DEPTH);
         write_word(a, DW'($urandom));
         read_check(a, "R3 visible next cycle");
         read_check(a ^ 1, "R5 adjacent bank");
         read_check((a + NB) % DEPTH, "R5 same bank");
      end

      // R8: old value during the write cycle, new value after.
      begin
         logic [DW-1:0] old_v;
         old_v = model[77];
         drive(77, ~old_v, 1'b1);
         check("R8 old value before edge", 77, rd_data, old_v);
         commit();
         drive(77, 16'h0, 1'b0);
         check("R3 new value after edge", 77, rd_data, ~old_v);
         commit();
      end

      // R2: address change with no clock edge in between.
      drive(100, 16'h0, 1'b0);
      check("R2 first address", 100, rd_data, model[100]);
      addr = AW'(301);
      #1;
      check("R2 address changed mid-cycle", 301, rd_data, model[301]);
      commit();

      // R7: random mix of reads and writes, checked before every edge.
      for (int i = 0; i < 2000; i++) begin
         int a;
         a = int'($urandom % DEPTH);
         drive(a, DW'($urandom), 1'($urandom % 2));
         check("R7 random mix", a, rd_data, model[a]);
         commit();
      end

      drive(0, 16'h0, 1'b0);
      finish_run();
   end

endmodule